// File: doc/BRIEF.md
# Interlaced SD Raster Timing Generator

This block produces the raster timing for interlaced standard-definition video. A pixel-rate clock enable steps it through each line and each frame. Two mode inputs set the raster: one picks 525-line or 625-line operation, the other picks rectangular or square pixel sampling. Together they give four line lengths and two frame structures, and each frame structure has two interlaced fields with their own active line ranges.

Outputs are the current pixel and line counts, horizontal and vertical sync, field identity, a blanking flag and an active-video flag. All outputs come from registers and change together on the same enabled clock edge. The mode inputs are sampled only when a new frame begins, so a mode change mid-frame does not break the raster. Pixel formatting, colour conversion, analog sync levels and locking to an external reference belong to other blocks.

Top module: `sd_raster_gen`

## Requirements
- R1: While reset is held, and until the first enabled cycle after it, `h_o`=0, `v_o`=0, `blank_o`=1 and `hsync_o`, `vsync_o`, `field_o`, `active_o` are all 0. The first enabled cycle moves the position to pixel 0 of line 1.
- R2: `h_o` counts 0 up to the line total minus 1, then returns to 0 and advances `v_o`. The line totals are: 858 for 525-line rectangular, 780 for 525-line square, 864 for 625-line rectangular and 944 for 625-line square.
- R3: Position and flags change only on clock edges where `pix_en_i` is 1. With `pix_en_i` at 0 they hold, and a sparse enable gives the same position as a dense one after the same number of enabled edges.
- R4: `v_o` runs from 1 to 525 in 525-line mode and from 1 to 625 in 625-line mode. After the last pixel of the last line, the next enabled edge goes to pixel 0 of line 1.
- R5: The active pixels are the last N pixels of each line. N is 720 (525 rectangular), 640 (525 square), 720 (625 rectangular) or 768 (625 square). The active region therefore starts at the line total minus N.
- R6: Active lines are 23–262 and 285–524 in 525-line mode, and 23–310 and 336–623 in 625-line mode.
- R7: `active_o` is 1 exactly when both the pixel and the line are active. `blank_o` is always its complement.
- R8: `hsync_o` is 1 for pixels 0 through 63 of every line.
- R9: `field_o` is 0 from line 1 until the second field starts, then 1 until the frame ends. The second field starts at line 263 in 525-line mode and at line 311 in 625-line mode.
- R10: `vsync_o` is 1 on the first 3 lines of each field: lines 1–3, plus lines 263–265 (525-line mode) or 311–313 (625-line mode).
- R11: `std625_i` (1 = 625-line) and `square_i` (1 = square sampling) are sampled only at the edge that starts a frame. Changes at any other time have no effect until that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_en_i | input | 1 | Pixel-rate clock enable |
| std625_i | input | 1 | 1 selects 625-line timing, 0 selects 525-line |
| square_i | input | 1 | 1 selects square pixel sampling, 0 rectangular |
| h_o | output | 10 | Pixel count within the line, 0-based |
| v_o | output | 10 | Line count within the frame, 1-based (0 before start) |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| blank_o | output | 1 | Blanking interval |
| field_o | output | 1 | 0 in first field, 1 in second |
| active_o | output | 1 | Active pixel on an active line |

## Verification
The bench builds the block with every line and pixel count shrunk: line totals of 18 to 24 pixels with 10 to 14 active, 13- and 15-line frames, a 4-pixel HSYNC and 2-line VSYNC. At that size a full frame in every mode, the field boundary, the wrap to line 1 and a mode change held back until the frame edge all fit in a few hundred enabled cycles. The RTL relates these sizes to the same parameters as the full standard values, so the boundary logic tested at this size is the logic used at the default size.

// File: rtl/sd_raster_pkg.sv
package sd_raster_pkg;
  localparam int unsigned HW = 10;
  localparam int unsigned VW = 10;

  typedef struct packed {
    logic std625;
    logic square;
  } mode_t;

  typedef struct packed {
    logic [HW-1:0] h_tot;
    logic [HW-1:0] h_start;
    logic [VW-1:0] v_tot;
    logic [VW-1:0] f2;
    logic [VW-1:0] a1s;
    logic [VW-1:0] a1e;
    logic [VW-1:0] a2s;
    logic [VW-1:0] a2e;
  } timing_t;

  typedef struct packed {
    logic hsync;
    logic vsync;
    logic blank;
    logic field;
    logic active;
  } flags_t;
endpackage

// File: rtl/sd_mode_table.sv
module sd_mode_table
  import sd_raster_pkg::*;
#(
  parameter int P525R_TOT = 858,
  parameter int P525R_ACT = 720,
  parameter int P525S_TOT = 780,
  parameter int P525S_ACT = 640,
  parameter int P625R_TOT = 864,
  parameter int P625R_ACT = 720,
  parameter int P625S_TOT = 944,
  parameter int P625S_ACT = 768,
  parameter int L525_TOT  = 525,
  parameter int L525_F2   = 263,
  parameter int L525_A1S  = 23,
  parameter int L525_A1E  = 262,
  parameter int L525_A2S  = 285,
  parameter int L525_A2E  = 524,
  parameter int L625_TOT  = 625,
  parameter int L625_F2   = 311,
  parameter int L625_A1S  = 23,
  parameter int L625_A1E  = 310,
  parameter int L625_A2S  = 336,
  parameter int L625_A2E  = 623
) (
  input  mode_t   mode_i,
  output timing_t tim_o
);
  always_comb begin
    if (mode_i.std625) begin
      tim_o.v_tot = VW'(L625_TOT);
      tim_o.f2    = VW'(L625_F2);
      tim_o.a1s   = VW'(L625_A1S);
      tim_o.a1e   = VW'(L625_A1E);
      tim_o.a2s   = VW'(L625_A2S);
      tim_o.a2e   = VW'(L625_A2E);
    end else begin
      tim_o.v_tot = VW'(L525_TOT);
      tim_o.f2    = VW'(L525_F2);
      tim_o.a1s   = VW'(L525_A1S);
      tim_o.a1e   = VW'(L525_A1E);
      tim_o.a2s   = VW'(L525_A2S);
      tim_o.a2e   = VW'(L525_A2E);
    end
    case ({mode_i.std625, mode_i.square})
      2'b00: begin
        tim_o.h_tot   = HW'(P525R_TOT);
        tim_o.h_start = HW'(P525R_TOT - P525R_ACT);
      end
      2'b01: begin
        tim_o.h_tot   = HW'(P525S_TOT);
        tim_o.h_start = HW'(P525S_TOT - P525S_ACT);
      end
      2'b10: begin
        tim_o.h_tot   = HW'(P625R_TOT);
        tim_o.h_start = HW'(P625R_TOT - P625R_ACT);
      end
      default: begin
        tim_o.h_tot   = HW'(P625S_TOT);
        tim_o.h_start = HW'(P625S_TOT - P625S_ACT);
      end
    endcase
  end
endmodule

// File: rtl/sd_pos_counter.sv
module sd_pos_counter
  import sd_raster_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pix_en_i,
  input  mode_t         mode_i,
  input  logic [HW-1:0] h_tot_i,
  input  logic [VW-1:0] v_tot_i,
  output logic [HW-1:0] h_o,
  output logic [VW-1:0] v_o,
  output logic [HW-1:0] h_n_o,
  output logic [VW-1:0] v_n_o,
  output mode_t         mode_n_o
);
  logic [HW-1:0] h_q, h_tot_q;
  logic [VW-1:0] v_q, v_tot_q;
  mode_t         mode_q;
  logic          last_h, frame_start;

  assign last_h      = (h_q == h_tot_q - HW'(1));
  assign frame_start = (v_q == '0) || (last_h && v_q == v_tot_q);
  assign mode_n_o    = frame_start ? mode_i : mode_q;

  always_comb begin
    if (frame_start) begin
      h_n_o = '0;
      v_n_o = VW'(1);
    end else if (last_h) begin
      h_n_o = '0;
      v_n_o = v_q + VW'(1);
    end else begin
      h_n_o = h_q + HW'(1);
      v_n_o = v_q;
    end
  end

  // line and frame totals latch with the mode at frame start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q     <= '0;
      v_q     <= '0;
      h_tot_q <= '0;
      v_tot_q <= '0;
      mode_q  <= '0;
    end else if (pix_en_i) begin
      h_q    <= h_n_o;
      v_q    <= v_n_o;
      mode_q <= mode_n_o;
      if (frame_start) begin
        h_tot_q <= h_tot_i;
        v_tot_q <= v_tot_i;
      end
    end
  end

  assign h_o = h_q;
  assign v_o = v_q;

  AST_HOLD_NO_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_en_i |=> ($stable(h_q) && $stable(v_q))); // R3
  AST_H_IN_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_q != '0) |-> (h_q < h_tot_q)); // R2
  AST_V_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_q <= v_tot_q || v_q == '0); // R4
  AST_MODE_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_q) |-> (h_q == '0 && v_q == VW'(1))); // R11
endmodule

// File: rtl/sd_sync_decode.sv
module sd_sync_decode
  import sd_raster_pkg::*;
#(
  parameter int HSYNC_LEN   = 64,
  parameter int VSYNC_LINES = 3
) (
  input  logic [HW-1:0] h_i,
  input  logic [VW-1:0] v_i,
  input  logic [HW-1:0] h_start_i,
  input  logic [VW-1:0] f2_i,
  input  logic [VW-1:0] a1s_i,
  input  logic [VW-1:0] a1e_i,
  input  logic [VW-1:0] a2s_i,
  input  logic [VW-1:0] a2e_i,
  output flags_t        flags_o
);
  logic h_act, v_act, second;

  assign h_act  = (h_i >= h_start_i);
  assign v_act  = (v_i >= a1s_i && v_i <= a1e_i) || (v_i >= a2s_i && v_i <= a2e_i);
  assign second = (v_i >= f2_i);

  always_comb begin
    flags_o.hsync  = (h_i < HW'(HSYNC_LEN));
    flags_o.vsync  = second ? (v_i < f2_i + VW'(VSYNC_LINES))
                            : (v_i <= VW'(VSYNC_LINES));
    flags_o.field  = second;
    flags_o.active = h_act && v_act;
    flags_o.blank  = !(h_act && v_act);
  end
endmodule

// File: rtl/sd_raster_gen.sv
module sd_raster_gen
  import sd_raster_pkg::*;
#(
  parameter int P525R_TOT   = 858,
  parameter int P525R_ACT   = 720,
  parameter int P525S_TOT   = 780,
  parameter int P525S_ACT   = 640,
  parameter int P625R_TOT   = 864,
  parameter int P625R_ACT   = 720,
  parameter int P625S_TOT   = 944,
  parameter int P625S_ACT   = 768,
  parameter int L525_TOT    = 525,
  parameter int L525_F2     = 263,
  parameter int L525_A1S    = 23,
  parameter int L525_A1E    = 262,
  parameter int L525_A2S    = 285,
  parameter int L525_A2E    = 524,
  parameter int L625_TOT    = 625,
  parameter int L625_F2     = 311,
  parameter int L625_A1S    = 23,
  parameter int L625_A1E    = 310,
  parameter int L625_A2S    = 336,
  parameter int L625_A2E    = 623,
  parameter int HSYNC_LEN   = 64,
  parameter int VSYNC_LINES = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         pix_en_i,
  input  logic                         std625_i,
  input  logic                         square_i,
  output logic [sd_raster_pkg::HW-1:0] h_o,
  output logic [sd_raster_pkg::VW-1:0] v_o,
  output logic                         hsync_o,
  output logic                         vsync_o,
  output logic                         blank_o,
  output logic                         field_o,
  output logic                         active_o
);
  mode_t         mode_in, mode_n;
  timing_t       tim;
  logic [HW-1:0] h_n;
  logic [VW-1:0] v_n;
  flags_t        flags_n, flags_q;

  assign mode_in = '{std625: std625_i, square: square_i};

  sd_mode_table #(
    .P525R_TOT(P525R_TOT), .P525R_ACT(P525R_ACT),
    .P525S_TOT(P525S_TOT), .P525S_ACT(P525S_ACT),
    .P625R_TOT(P625R_TOT), .P625R_ACT(P625R_ACT),
    .P625S_TOT(P625S_TOT), .P625S_ACT(P625S_ACT),
    .L525_TOT(L525_TOT), .L525_F2(L525_F2),
    .L525_A1S(L525_A1S), .L525_A1E(L525_A1E),
    .L525_A2S(L525_A2S), .L525_A2E(L525_A2E),
    .L625_TOT(L625_TOT), .L625_F2(L625_F2),
    .L625_A1S(L625_A1S), .L625_A1E(L625_A1E),
    .L625_A2S(L625_A2S), .L625_A2E(L625_A2E)
  ) u_table (
    .mode_i (mode_n),
    .tim_o  (tim)
  );

  sd_pos_counter u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pix_en_i (pix_en_i),
    .mode_i   (mode_in),
    .h_tot_i  (tim.h_tot),
    .v_tot_i  (tim.v_tot),
    .h_o      (h_o),
    .v_o      (v_o),
    .h_n_o    (h_n),
    .v_n_o    (v_n),
    .mode_n_o (mode_n)
  );

  sd_sync_decode #(
    .HSYNC_LEN  (HSYNC_LEN),
    .VSYNC_LINES(VSYNC_LINES)
  ) u_dec (
    .h_i       (h_n),
    .v_i       (v_n),
    .h_start_i (tim.h_start),
    .f2_i      (tim.f2),
    .a1s_i     (tim.a1s),
    .a1e_i     (tim.a1e),
    .a2s_i     (tim.a2s),
    .a2e_i     (tim.a2e),
    .flags_o   (flags_n)
  );

  // flags decoded from the next position so they line up with the counters
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= flags_t'(5'b00100);
    else if (pix_en_i) flags_q <= flags_n;
  end

  assign hsync_o  = flags_q.hsync;
  assign vsync_o  = flags_q.vsync;
  assign blank_o  = flags_q.blank;
  assign field_o  = flags_q.field;
  assign active_o = flags_q.active;

  AST_IDLE_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_o == '0) |-> (blank_o && !active_o && !hsync_o && !vsync_o)); // R1
  AST_HSYNC_BLANKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hsync_o |-> blank_o); // R8
  AST_VSYNC_BLANKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsync_o |-> blank_o); // R10
  AST_FIELD_ON_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(field_o) |-> (h_o == '0)); // R9
  AST_FIELD_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(field_o) |-> (v_o == VW'(1))); // R4
endmodule

// File: tb/sd_raster_gen_test.sv
`timescale 1ns/1ps
module sd_raster_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pix_en = 1'b0;
  logic       std625 = 1'b0;
  logic       square = 1'b0;
  logic [9:0] h, v;
  logic       hsync, vsync, blank, field, active;
  int         tests = 0;
  int         fails = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  sd_raster_gen #(
    .P525R_TOT(20), .P525R_ACT(12), .P525S_TOT(18), .P525S_ACT(10),
    .P625R_TOT(22), .P625R_ACT(12), .P625S_TOT(24), .P625S_ACT(14),
    .L525_TOT(13), .L525_F2(7), .L525_A1S(3), .L525_A1E(5),
    .L525_A2S(9), .L525_A2E(12),
    .L625_TOT(15), .L625_F2(8), .L625_A1S(3), .L625_A1E(6),
    .L625_A2S(10), .L625_A2E(14),
    .HSYNC_LEN(4), .VSYNC_LINES(2)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .pix_en_i(pix_en),
    .std625_i(std625), .square_i(square),
    .h_o(h), .v_o(v), .hsync_o(hsync), .vsync_o(vsync),
    .blank_o(blank), .field_o(field), .active_o(active)
  );

  typedef struct packed {
    logic       std;
    logic       sq;
    logic [15:0] pulses;
    logic [9:0] h;
    logic [9:0] v;
    logic [4:0] fl;   // {hsync,vsync,blank,field,active}
    logic [3:0] req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,16'd1,  10'd0, 10'd1, 5'b11100,4'd1},  // R1 first step
    '{1'b0,1'b0,16'd48, 10'd7, 10'd3, 5'b00100,4'd5},  // R5 edge before active
    '{1'b0,1'b0,16'd49, 10'd8, 10'd3, 5'b00001,4'd5},  // R5 first active
    '{1'b0,1'b0,16'd100,10'd19,10'd5, 5'b00001,4'd6},  // R6 last line field 1
    '{1'b0,1'b0,16'd124,10'd3, 10'd7, 5'b11110,4'd9},  // R9 second field start
    '{1'b0,1'b0,16'd171,10'd10,10'd9, 5'b00011,4'd6},  // R6 field 2 active
    '{1'b0,1'b0,16'd260,10'd19,10'd13,5'b00110,4'd4},  // R4 last pixel
    '{1'b0,1'b0,16'd261,10'd0, 10'd1, 5'b11100,4'd4},  // R4 wrap
    '{1'b0,1'b1,16'd63, 10'd8, 10'd4, 5'b00001,4'd2},  // R2 square line length
    '{1'b0,1'b1,16'd18, 10'd17,10'd1, 5'b01100,4'd8},  // R8 hsync off
    '{1'b1,1'b0,16'd121,10'd10,10'd6, 5'b00001,4'd6},  // R6 625 active
    '{1'b1,1'b0,16'd120,10'd9, 10'd6, 5'b00100,4'd5},  // R5 625 edge
    '{1'b1,1'b0,16'd155,10'd0, 10'd8, 5'b11110,4'd10}, // R10 vsync field 2
    '{1'b1,1'b1,16'd336,10'd23,10'd14,5'b00011,4'd2},  // R2 625 square
    '{1'b1,1'b1,16'd342,10'd5, 10'd15,5'b00110,4'd4},  // R4 625 last line
    '{1'b1,1'b1,16'd226,10'd9, 10'd10,5'b00110,4'd10}  // R10 vsync over
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n  = 1'b0;
    pix_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pix_en = 1'b1;
    end
    @(negedge clk);
    pix_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R1 reset state
    check("R1", "h", h, 0);
    check("R1", "v", v, 0);
    check("R1", "blank", blank, 1);
    check("R1", "flags", {hsync, vsync, field, active}, 0);

    for (int k = 0; k < NV; k++) begin
      std625 = VECS[k].std;
      square = VECS[k].sq;
      do_reset();
      pulse(int'(VECS[k].pulses));
      check($sformatf("R%0d", VECS[k].req), "h", h, int'(VECS[k].h));
      check($sformatf("R%0d", VECS[k].req), "v", v, int'(VECS[k].v));
      check($sformatf("R%0d", VECS[k].req), "flags",
            {hsync, vsync, blank, field, active}, int'(VECS[k].fl));
      check("R7", "blank vs active", blank, int'(!active));
    end

    // R3 hold when enable is low
    std625 = 1'b0; square = 1'b0;
    do_reset();
    pulse(49);
    repeat (5) @(negedge clk);
    check("R3", "hold h", h, 8);
    check("R3", "hold v", v, 3);
    check("R3", "hold active", active, 1);

    // R3 sparse enable
    do_reset();
    for (int i = 0; i < 10; i++) begin
      pulse(1);
      @(negedge clk);
    end
    check("R3", "sparse h", h, 9);
    check("R3", "sparse v", v, 1);

    // R11 mode change waits for frame start
    do_reset();
    pulse(30);
    std625 = 1'b1; square = 1'b1;
    pulse(10);
    check("R11", "old line length h", h, 19);
    check("R11", "old line length v", v, 2);
    pulse(220);
    check("R11", "old frame end v", v, 13);
    check("R11", "old frame end field", field, 1);
    pulse(1);
    check("R11", "new frame h", h, 0);
    check("R11", "new frame v", v, 1);
    pulse(23);
    check("R11", "new line length h", h, 23);
    check("R11", "new line length v", v, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule